// File: doc/BRIEF.md
# Serial Register Access Channel

This block is the register side of an encoder slave's serial link. The master moves one bit per strobe. It sends a command made of a slave identity, a register address and a direction flag, protected by a short check code. The slave compares the identity with its strap pins and checks the code. For a read it answers on its serial output with one data byte and a check code over that byte. For a write it takes a data byte and a check code and stores the byte only when every check passes.

A gap with no strobes marks the end of a frame. The length of that gap is chosen by a 2-bit field in a configuration register, in units of a reference count of REF_DIV clock cycles. The register space has three regions. Configuration bytes and user bytes are writable storage. Identifier bytes are read-only and fixed by a parameter. Addresses below the configuration region are not implemented.

Top module: `regacc_slave`

## Requirements
- R1: After reset `dout_o` is 0 and the frame timeout code is 0, so the longest timeout applies. A new command sent after a gap longer than the code-1 limit but shorter than the code-0 limit is ignored.
- R2: A command is 15 bits, MSB first, one per strobe: ID[2:0], address[6:0], a direction bit (1 = write, 0 = read), then the check code. The check is CRC x^4+x+1, initial value 0, computed over the first 11 bits and sent bitwise inverted.
- R3: A read answers with 12 bits on `dout_o`, MSB first: 8 data bits, then the inverted CRC (same polynomial, initial 0) over those 8 bits. The first bit appears in the cycle after the strobe that carries the last command check bit. Each later strobe advances one bit. After the 12th such strobe `dout_o` returns to 0 and stays there until the next read.
- R4: A command whose ID differs from `slave_id_i`, or whose check code is wrong, gets no answer. Every later strobe is ignored until the timeout expires.
- R5: A write command is followed by 8 data bits, MSB first, and their inverted 4-bit CRC. When that check is correct, a write to 0x10-0x77 is stored and a later read of the address returns the byte.
- R6: A write whose data check code is wrong leaves the addressed register unchanged.
- R7: Writes to 0x78-0x7F and below 0x10 are discarded. A read of 0x78+k returns bits [8k+7:8k] of `ID_BYTES`.
- R8: A read of an address below 0x10 returns 0x00 with a valid check code.
- R9: A frame ends when LIMIT clock cycles pass with no strobe. LIMIT = counts x REF_DIV, where counts is 2049, 513 or 67 for codes 0, 1 and 2. The code is held in bits [7:6] of register 0x10.
- R10: Code 3 selects the code-0 limit of 2049 counts.
- R11: When the timeout expires partway through a command, the partial command is dropped and the next strobe starts a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| slave_id_i | input | 3 | Strapped slave identity |
| stb_i | input | 1 | One-cycle bit strobe from the master |
| din_i | input | 1 | Serial data from the master, valid with `stb_i` |
| dout_o | output | 1 | Registered serial answer to the master |

## Verification
The first answer bit is due one cycle after the strobe that completes the command. Every later bit is due one cycle after its strobe. The bench samples each of these on the falling edge that follows the strobe's rising edge. Write results are not visible at the ports, so each one is checked by a later read, issued only after a full timeout gap. Timeout windows are probed with margins of at least five cycles on each side of LIMIT, so no check depends on the exact edge where the frame resets.

// File: rtl/regacc_pkg.sv
package regacc_pkg;
  localparam int RA_AW = 7;
  localparam int RA_DW = 8;
  localparam logic [RA_AW-1:0] RA_CFG_LO = 7'h10;
  localparam logic [RA_AW-1:0] RA_ID_LO  = 7'h78;
  localparam logic [RA_AW-1:0] RA_CFG_TMO_ADR = 7'h10;

  typedef enum logic [1:0] {ST_IDLE, ST_RSP, ST_WDATA, ST_WAIT} ra_state_e;
  typedef enum logic [1:0] {RG_NONE, RG_MEM, RG_ID} ra_region_e;

  function automatic logic [3:0] crc4_step(input logic [3:0] c, input logic b);
    logic fb;
    fb = c[3] ^ b;
    return {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
  endfunction

  function automatic logic [3:0] crc4_byte(input logic [RA_DW-1:0] d);
    logic [3:0] c;
    c = 4'h0;
    for (int i = RA_DW-1; i >= 0; i--) c = crc4_step(c, d[i]);
    return c;
  endfunction

  function automatic ra_region_e region_of(input logic [RA_AW-1:0] a);
    if (a >= RA_ID_LO) return RG_ID;
    if (a >= RA_CFG_LO) return RG_MEM;
    return RG_NONE;
  endfunction
endpackage

// File: rtl/regacc_timer.sv
module regacc_timer #(
  parameter int REF_DIV = 32,
  parameter int CNT0 = 2049,
  parameter int CNT1 = 513,
  parameter int CNT2 = 67
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       stb_i,
  input  logic [1:0] code_i,
  output logic       tmo_o
);
  localparam int LIM0 = CNT0 * REF_DIV;
  localparam int LIM1 = CNT1 * REF_DIV;
  localparam int LIM2 = CNT2 * REF_DIV;
  localparam int CW = $clog2(LIM0 + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          armed_q;

  always_comb begin
    case (code_i)
      2'd1:    lim = CW'(LIM1);
      2'd2:    lim = CW'(LIM2);
      default: lim = CW'(LIM0);  // code 0 and the forbidden code 3
    endcase
  end

  assign tmo_o = armed_q && !stb_i && (cnt_q >= lim - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (stb_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (tmo_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (armed_q) begin
      cnt_q   <= cnt_q + CW'(1);
    end
  end

  AST_TMO_MIN_GAP: assert property (@(posedge clk) disable iff (rst)
    tmo_o |-> cnt_q >= CW'(LIM2 - 1));  // R9
  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tmo_o |=> !tmo_o);  // R9
endmodule

// File: rtl/regacc_store.sv
module regacc_store
  import regacc_pkg::*;
#(
  parameter logic [63:0] ID_BYTES = 64'h1E2D3C4B5A697887
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RA_AW-1:0] adr_i,
  input  logic             wr_en_i,
  input  logic [RA_DW-1:0] wr_data_i,
  output logic [RA_DW-1:0] rd_data_o,
  output logic [1:0]       tmo_code_o
);
  localparam int DEPTH = int'(RA_ID_LO) - int'(RA_CFG_LO);
  localparam int ID_N  = (1 << RA_AW) - int'(RA_ID_LO);
  localparam int IW    = $clog2(DEPTH);
  localparam int IDW   = $clog2(ID_N);

  logic [RA_DW-1:0] mem [DEPTH];
  logic [RA_DW-1:0] mem_q;
  logic [RA_DW-1:0] id_q;
  ra_region_e       rg_q;
  logic [1:0]       code_q;
  logic [RA_AW-1:0] mem_off;
  logic [RA_AW-1:0] id_off;
  logic [IW-1:0]    midx;

  assign mem_off = adr_i - RA_CFG_LO;
  assign id_off  = adr_i - RA_ID_LO;
  assign midx    = (region_of(adr_i) == RG_MEM) ? mem_off[IW-1:0] : '0;

  // storage: plain synchronous write and read for RAM inference
  always_ff @(posedge clk) begin
    if (wr_en_i) mem[midx] <= wr_data_i;
    mem_q <= mem[midx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rg_q   <= RG_NONE;
      id_q   <= '0;
      code_q <= 2'd0;
    end else begin
      rg_q <= region_of(adr_i);
      id_q <= ID_BYTES[id_off[IDW-1:0]*RA_DW +: RA_DW];
      if (wr_en_i && adr_i == RA_CFG_TMO_ADR) code_q <= wr_data_i[7:6];
    end
  end

  always_comb begin
    case (rg_q)
      RG_MEM:  rd_data_o = mem_q;
      RG_ID:   rd_data_o = id_q;
      default: rd_data_o = '0;
    endcase
  end
  assign tmo_code_o = code_q;

  AST_WR_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    wr_en_i |-> region_of(adr_i) == RG_MEM);  // R7
endmodule

// File: rtl/regacc_frame.sv
module regacc_frame
  import regacc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       slave_id_i,
  input  logic             stb_i,
  input  logic             din_i,
  input  logic             tmo_i,
  input  logic [RA_DW-1:0] rd_data_i,
  output logic [RA_AW-1:0] adr_o,
  output logic             wr_en_o,
  output logic [RA_DW-1:0] wr_data_o,
  output logic             dout_o
);
  localparam int CMD_W = 3 + RA_AW + 1;
  localparam int RSP_W = RA_DW + 4;

  ra_state_e        state_q;
  logic [3:0]       cnt_q;
  logic [3:0]       crc_q;
  logic [3:0]       rx_crc_q;
  logic [CMD_W-1:0] cmd_q;
  logic [RA_DW-1:0] wdat_q;
  logic [RSP_W-1:0] rsp_q;
  logic             wr_q;
  logic             chk_ok;
  logic             cmd_ok;

  assign chk_ok = ({rx_crc_q[2:0], din_i} == ~crc_q);
  assign cmd_ok = chk_ok && (cmd_q[CMD_W-1 -: 3] == slave_id_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      crc_q    <= '0;
      rx_crc_q <= '0;
      cmd_q    <= '0;
      wdat_q   <= '0;
      rsp_q    <= '0;
      wr_q     <= 1'b0;
    end else begin
      wr_q <= 1'b0;
      if (tmo_i) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
        crc_q   <= '0;
        rsp_q   <= '0;
      end else if (stb_i) begin
        case (state_q)
          ST_IDLE: begin
            if (cnt_q < 4'(CMD_W)) begin
              cmd_q <= {cmd_q[CMD_W-2:0], din_i};
              crc_q <= crc4_step(crc_q, din_i);
              cnt_q <= cnt_q + 4'd1;
            end else if (cnt_q < 4'(CMD_W + 3)) begin
              rx_crc_q <= {rx_crc_q[2:0], din_i};
              cnt_q    <= cnt_q + 4'd1;
            end else begin
              cnt_q <= '0;
              crc_q <= '0;
              if (!cmd_ok) state_q <= ST_WAIT;
              else if (cmd_q[0]) state_q <= ST_WDATA;
              else begin
                state_q <= ST_RSP;
                rsp_q   <= {rd_data_i, ~crc4_byte(rd_data_i)};
              end
            end
          end
          ST_RSP: begin
            rsp_q <= {rsp_q[RSP_W-2:0], 1'b0};
            if (cnt_q == 4'(RSP_W - 1)) begin
              state_q <= ST_WAIT;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 4'd1;
          end
          ST_WDATA: begin
            if (cnt_q < 4'(RA_DW)) begin
              wdat_q <= {wdat_q[RA_DW-2:0], din_i};
              crc_q  <= crc4_step(crc_q, din_i);
              cnt_q  <= cnt_q + 4'd1;
            end else if (cnt_q < 4'(RA_DW + 3)) begin
              rx_crc_q <= {rx_crc_q[2:0], din_i};
              cnt_q    <= cnt_q + 4'd1;
            end else begin
              state_q <= ST_WAIT;
              cnt_q   <= '0;
              wr_q    <= chk_ok && (region_of(adr_o) == RG_MEM);
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign adr_o     = cmd_q[RA_AW:1];
  assign wr_en_o   = wr_q;
  assign wr_data_o = wdat_q;
  assign dout_o    = rsp_q[RSP_W-1];

  AST_DOUT_QUIET: assert property (@(posedge clk) disable iff (rst)
    state_q != ST_RSP |-> !dout_o);  // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= 4'(CMD_W + 3));  // R2
  AST_WR_AFTER_CHECK: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> state_q == ST_WAIT);  // R5
  AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst)
    tmo_i |=> state_q == ST_IDLE && cnt_q == 4'd0);  // R11
endmodule

// File: rtl/regacc_slave.sv
module regacc_slave
  import regacc_pkg::*;
#(
  parameter int          REF_DIV  = 32,
  parameter logic [63:0] ID_BYTES = 64'h1E2D3C4B5A697887
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] slave_id_i,
  input  logic       stb_i,
  input  logic       din_i,
  output logic       dout_o
);
  logic             tmo;
  logic [1:0]       tmo_code;
  logic [RA_AW-1:0] adr;
  logic             wr_en;
  logic [RA_DW-1:0] wr_data;
  logic [RA_DW-1:0] rd_data;

  regacc_timer #(.REF_DIV(REF_DIV)) timer_i (
    .clk(clk), .rst(rst), .stb_i(stb_i), .code_i(tmo_code), .tmo_o(tmo)
  );

  regacc_store #(.ID_BYTES(ID_BYTES)) store_i (
    .clk(clk), .rst(rst), .adr_i(adr), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tmo_code_o(tmo_code)
  );

  regacc_frame frame_i (
    .clk(clk), .rst(rst), .slave_id_i(slave_id_i), .stb_i(stb_i), .din_i(din_i),
    .tmo_i(tmo), .rd_data_i(rd_data), .adr_o(adr), .wr_en_o(wr_en),
    .wr_data_o(wr_data), .dout_o(dout_o)
  );
endmodule

// File: tb/regacc_slave_tb_top.sv
module regacc_slave_tb_top;
  localparam int REF = 2;
  localparam logic [63:0] IDB = 64'h1E2D3C4B5A697887;
  localparam logic [2:0] MY_ID = 3'd5;
  localparam int L0 = 2049 * REF;
  localparam int L1 = 513 * REF;
  localparam int L2 = 67 * REF;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stb = 1'b0;
  logic din = 1'b0;
  logic dout;
  int total = 0;
  int bad = 0;
  int lim = L0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  regacc_slave #(.REF_DIV(REF), .ID_BYTES(IDB)) dut_i (
    .clk(clk), .rst(rst), .slave_id_i(MY_ID), .stb_i(stb), .din_i(din), .dout_o(dout)
  );

  function automatic logic [3:0] crc_calc(input logic [15:0] v, input int n);
    logic [3:0] c = 4'h0;
    for (int i = n - 1; i >= 0; i--) begin
      logic fb = c[3] ^ v[i];
      c = {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk); stb = 1'b1; din = b;
    @(negedge clk); stb = 1'b0; din = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (lim + 5) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [2:0] id, input logic [6:0] adr, input logic wnr, input logic corrupt);
    logic [10:0] w = {id, adr, wnr};
    logic [3:0] c = ~crc_calc({5'd0, w}, 11) ^ {3'b0, corrupt};
    for (int i = 10; i >= 0; i--) send_bit(w[i]);
    for (int i = 3; i >= 0; i--) send_bit(c[i]);
  endtask

  // read; answer must be data then inverted CRC, dout back to 0 afterwards
  task automatic do_read(input logic [6:0] adr, input logic [7:0] exp, input string req);
    logic [11:0] got;
    send_cmd(MY_ID, adr, 1'b0, 1'b0);
    got[11] = dout;
    for (int j = 1; j < 12; j++) begin
      send_bit(1'b0);
      got[11 - j] = dout;
    end
    send_bit(1'b0);
    chk(req, {20'd0, got}, {20'd0, exp, ~crc_calc({8'd0, exp}, 8)});
    chk({req, "/R3 end"}, {31'd0, dout}, 32'd0);
  endtask

  task automatic do_write(input logic [6:0] adr, input logic [7:0] d, input logic corrupt);
    logic [3:0] c = ~crc_calc({8'd0, d}, 8) ^ {3'b0, corrupt};
    send_cmd(MY_ID, adr, 1'b1, 1'b0);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    for (int i = 3; i >= 0; i--) send_bit(c[i]);
  endtask

  // command that must get no answer at all
  task automatic no_resp(input logic [2:0] id, input logic [6:0] adr, input logic corrupt, input string req);
    logic seen;
    send_cmd(id, adr, 1'b0, corrupt);
    seen = dout;
    for (int j = 0; j < 12; j++) begin
      send_bit(1'b0);
      seen |= dout;
    end
    chk(req, {31'd0, seen}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 dout after reset", {31'd0, dout}, 32'd0);
    do_read(7'h05, 8'h00, "R8 read 0x05");
    repeat (L1 + 5) @(negedge clk);
    no_resp(MY_ID, 7'h05, 1'b0, "R1 code0 still waiting");
    settle();
    do_read(7'h05, 8'h00, "R8 read unimplemented");
    settle();
  endtask

  task automatic t_write_read();
    do_write(7'h10, 8'h80, 1'b0);   // timeout code 2
    settle();
    lim = L2;
    do_read(7'h10, 8'h80, "R5 cfg readback");  settle();
    do_write(7'h25, 8'h5A, 1'b0);  settle();
    do_read(7'h25, 8'h5A, "R5 user 0x25");     settle();
    do_write(7'h77, 8'hC3, 1'b0);  settle();
    do_read(7'h77, 8'hC3, "R5 user 0x77");     settle();
  endtask

  task automatic t_bad_data();
    do_write(7'h25, 8'h11, 1'b1);  settle();
    do_read(7'h25, 8'h5A, "R6 bad data crc");  settle();
  endtask

  task automatic t_regions();
    do_write(7'h78, 8'hFF, 1'b0);  settle();
    do_read(7'h78, IDB[7:0], "R7 id byte 0");  settle();
    do_read(7'h7F, IDB[63:56], "R7 id byte 7"); settle();
    do_write(7'h03, 8'h44, 1'b0);  settle();
    do_read(7'h03, 8'h00, "R7 R8 low write dropped"); settle();
  endtask

  task automatic t_reject();
    no_resp(3'd2, 7'h25, 1'b0, "R4 id mismatch");      settle();
    no_resp(MY_ID, 7'h25, 1'b1, "R4 bad cmd crc");     
    no_resp(MY_ID, 7'h25, 1'b0, "R4 ignored until timeout"); settle();
    do_read(7'h25, 8'h5A, "R4 recovers");              settle();
  endtask

  task automatic t_timeout();
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    settle();
    do_read(7'h77, 8'hC3, "R11 partial dropped");
    repeat (L2 - 20) @(negedge clk);
    no_resp(MY_ID, 7'h77, 1'b0, "R9 before limit");
    settle();
    do_read(7'h77, 8'hC3, "R9 after limit");          settle();
    do_write(7'h10, 8'hC0, 1'b0);                     // code 3
    lim = L0;
    settle();
    do_read(7'h10, 8'hC0, "R10 cfg code3");
    repeat (L1 + 5) @(negedge clk);
    no_resp(MY_ID, 7'h10, 1'b0, "R10 fallback long");
    settle();
    do_read(7'h10, 8'hC0, "R10 after long gap");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_read();
    t_bad_data();
    t_regions();
    t_reject();
    t_timeout();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule